// File: doc/BRIEF.md
# Noise-Shaped Sign-Magnitude DAC Code Generator

This block sits between an interpolating filter and a bank of segmented current-steering converters. On each strobe at the four-times oversampled rate it takes one wide two's-complement audio sample per channel. It requantises the sample to a 15-bit code with a first-order error-feedback loop. The code's residue is not thrown away. It is carried into the next sample, which pushes the requantisation noise up out of the audio band.

The requantised value is then recoded into sign-magnitude form and split into three fields. The sign bit sets the current direction. The upper five magnitude bits become a 31-line thermometer vector that switches the coarse current segments. The lower nine magnitude bits stay binary and drive the fine divider. Each channel has its own error state and its own output registers. The outputs change only on a strobe and hold their value between strobes.

Top module: `nssm_dac_encoder`

## Requirements
- R1: While rst_n is low at a clock edge, every output register clears to zero, and so does every channel's stored error.
- R2: On a strobe, each channel forms sum = sample + e. Here e is the stored 7-bit unsigned error. The requantised value is floor(sum / 128), and the new stored error is sum mod 128.
- R3: A requantised value outside [-16384, 16383] clamps to the nearest bound. The stored error is still sum mod 128.
- R4: dac_sign is 1 exactly when the requantised value is negative. The magnitude is its absolute value, except that -16384 gives magnitude 16383.
- R5: A requantised value of zero gives sign 0, all thermometer lines low and fine field 0. A sign of 1 never appears with zero magnitude.
- R6: The coarse value is magnitude bits [13:9], a number from 0 to 31. Thermometer line k (k = 0..30) is high exactly when the coarse value is greater than k.
- R7: The fine field equals magnitude bits [8:0].
- R8: The outputs take new values at the clock edge where smp_valid is sampled high. When smp_valid is low, the outputs and the stored error do not change.
- R9: Channel n uses only sample slice n, at bits [22n+21 : 22n], and only its own stored error. It drives only its own output slices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new sample on every channel |
| smp_data | input | 88 | Four 22-bit two's-complement samples, channel n at [22n+21:22n] |
| dac_sign | output | 4 | Current direction per channel, 1 = negative |
| dac_therm | output | 124 | 31 coarse segment lines per channel, channel n at [31n+30:31n] |
| dac_fine | output | 36 | 9-bit fine field per channel, channel n at [9n+8:9n] |

## Verification
Every output is due one clock edge after a strobe is presented. The sign, thermometer and fine fields all come from the same register stage. The stored error takes effect on the next strobe, so a wrong feedback term only shows up one strobe later. The bench drives inputs on the falling edge and samples just after the rising edge. It advances its behavioural model at that rising edge and compares every channel's fields on every clock. This covers cycles with no strobe, where the outputs must hold.

// File: rtl/nssm_pkg.sv
// Package: default dimensions shared by the DAC code generator modules.
// Assumes: the code width exceeds the fine width and is narrower than the input.
package nssm_pkg;
    localparam int DEF_IN_W   = 22;  // input sample width
    localparam int DEF_CODE_W = 15;  // requantised sign-magnitude code width
    localparam int DEF_FINE_W = 9;   // binary fine field width
    localparam int DEF_NUM_CH = 4;   // channel count
endpackage

// File: rtl/nssm_shaper.sv
// Module: first-order error-feedback requantiser.
// Adds the stored residue to the sample, keeps the upper bits as a clamped
// CODE_W-bit two's-complement value, and stores the new residue on a strobe.
// Assumes: IN_W > CODE_W; the residue is treated as an unsigned fraction.
module nssm_shaper #(
    parameter int IN_W   = nssm_pkg::DEF_IN_W,
    parameter int CODE_W = nssm_pkg::DEF_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld,
    input  logic [IN_W-1:0]          x,
    output logic signed [CODE_W-1:0] q
);
    localparam int FRAC_W = IN_W - CODE_W;
    localparam int SUM_W  = IN_W + 1;
    localparam logic signed [CODE_W:0] Q_MAX = $signed({2'b00, {(CODE_W-1){1'b1}}});
    localparam logic signed [CODE_W:0] Q_MIN = $signed({2'b11, {(CODE_W-1){1'b0}}});

    logic [FRAC_W-1:0]        err_q;
    logic [SUM_W-1:0]         sum;
    logic signed [CODE_W:0]   q_wide;

    // Add the sign-extended sample and the zero-extended residue.
    always_comb begin
        sum    = {x[IN_W-1], x} + {{(SUM_W-FRAC_W){1'b0}}, err_q};
        q_wide = $signed(sum[SUM_W-1:FRAC_W]);
    end

    // Clamp the requantised value into the CODE_W-bit range.
    always_comb begin
        if (q_wide > Q_MAX)
            q = Q_MAX[CODE_W-1:0];
        else if (q_wide < Q_MIN)
            q = Q_MIN[CODE_W-1:0];
        else
            q = q_wide[CODE_W-1:0];
    end

    // Store the residue only when a strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= '0;
        else if (vld)
            err_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/nssm_sm_conv.sv
// Module: two's-complement to sign-magnitude converter.
// Saturates the most negative code to the largest magnitude, so the magnitude
// always fits in CODE_W-1 bits. Zero always leaves with a positive sign.
// Assumes: CODE_W >= 2.
module nssm_sm_conv #(
    parameter int CODE_W = nssm_pkg::DEF_CODE_W
) (
    input  logic signed [CODE_W-1:0] q,
    output logic                     sgn,
    output logic [CODE_W-2:0]        mag
);
    localparam int MAG_W = CODE_W - 1;
    localparam logic [CODE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

    logic [CODE_W-1:0] neg;

    // Take the absolute value, with the negative limit saturated.
    always_comb begin
        neg = -q;
        sgn = q[CODE_W-1];
        if (!q[CODE_W-1])
            mag = q[MAG_W-1:0];
        else if (q == MOST_NEG)
            mag = {MAG_W{1'b1}};
        else
            mag = neg[MAG_W-1:0];
    end
endmodule

// File: rtl/nssm_therm_dec.sv
// Module: binary to thermometer decoder for the coarse segment lines.
// Line k is high when the coarse value exceeds k, giving a monotonic fill.
// Assumes: COARSE_W is small (2**COARSE_W-1 output lines).
module nssm_therm_dec #(
    parameter int COARSE_W = 5
) (
    input  logic [COARSE_W-1:0]         coarse,
    output logic [(1<<COARSE_W)-2:0]    therm
);
    localparam int SEG_N = (1 << COARSE_W) - 1;

    // One magnitude comparison per segment line.
    for (genvar k = 0; k < SEG_N; k++) begin : g_line
        assign therm[k] = (coarse > COARSE_W'(k));
    end
endmodule

// File: rtl/nssm_channel.sv
// Module: one channel of the code path: shaper, sign-magnitude conversion,
// field split and output registers that load on a strobe.
// Assumes: CODE_W-1 > FINE_W, so a coarse field exists.
module nssm_channel #(
    parameter int IN_W   = nssm_pkg::DEF_IN_W,
    parameter int CODE_W = nssm_pkg::DEF_CODE_W,
    parameter int FINE_W = nssm_pkg::DEF_FINE_W
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      vld,
    input  logic [IN_W-1:0]                           x,
    output logic                                      sgn_o,
    output logic [(1<<(CODE_W-1-FINE_W))-2:0]         therm_o,
    output logic [FINE_W-1:0]                         fine_o
);
    localparam int MAG_W    = CODE_W - 1;
    localparam int COARSE_W = MAG_W - FINE_W;
    localparam int SEG_N    = (1 << COARSE_W) - 1;

    logic signed [CODE_W-1:0] q;
    logic                     sgn;
    logic [MAG_W-1:0]         mag;
    logic [SEG_N-1:0]         therm;

    nssm_shaper #(.IN_W(IN_W), .CODE_W(CODE_W)) u_shaper (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (vld),
        .x     (x),
        .q     (q)
    );

    nssm_sm_conv #(.CODE_W(CODE_W)) u_conv (
        .q   (q),
        .sgn (sgn),
        .mag (mag)
    );

    nssm_therm_dec #(.COARSE_W(COARSE_W)) u_therm (
        .coarse (mag[MAG_W-1:FINE_W]),
        .therm  (therm)
    );

    // Register the three converter fields on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_o   <= 1'b0;
            therm_o <= '0;
            fine_o  <= '0;
        end else if (vld) begin
            sgn_o   <= sgn;
            therm_o <= therm;
            fine_o  <= mag[FINE_W-1:0];
        end
    end
endmodule

// File: rtl/nssm_dac_encoder.sv
// Module: multi-channel noise-shaped sign-magnitude DAC code generator (top).
// Splits the packed sample bus into channels, each with its own error state.
// Assumes: one shared strobe marks new samples on every channel.
module nssm_dac_encoder #(
    parameter int NUM_CH = nssm_pkg::DEF_NUM_CH,
    parameter int IN_W   = nssm_pkg::DEF_IN_W,
    parameter int CODE_W = nssm_pkg::DEF_CODE_W,
    parameter int FINE_W = nssm_pkg::DEF_FINE_W,
    localparam int SEG_N = (1 << (CODE_W - 1 - FINE_W)) - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [NUM_CH*IN_W-1:0]   smp_data,
    output logic [NUM_CH-1:0]        dac_sign,
    output logic [NUM_CH*SEG_N-1:0]  dac_therm,
    output logic [NUM_CH*FINE_W-1:0] dac_fine
);
    // One independent code path per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        nssm_channel #(.IN_W(IN_W), .CODE_W(CODE_W), .FINE_W(FINE_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (smp_valid),
            .x       (smp_data[ch*IN_W +: IN_W]),
            .sgn_o   (dac_sign[ch]),
            .therm_o (dac_therm[ch*SEG_N +: SEG_N]),
            .fine_o  (dac_fine[ch*FINE_W +: FINE_W])
        );
    end
endmodule

// File: rtl/nssm_dac_encoder_chk.sv
// Module: assertion checker bound to the code generator top.
// Assumes: the same parameters as the top it is bound to.
module nssm_dac_encoder_chk #(
    parameter int NUM_CH = 4,
    parameter int IN_W   = 22,
    parameter int FINE_W = 9,
    parameter int SEG_N  = 31
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_valid,
    input logic [NUM_CH*IN_W-1:0]   smp_data,
    input logic [NUM_CH-1:0]        dac_sign,
    input logic [NUM_CH*SEG_N-1:0]  dac_therm,
    input logic [NUM_CH*FINE_W-1:0] dac_fine
);
    // R1: the cycle after reset, all outputs are clear.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dac_sign == '0 && dac_therm == '0 && dac_fine == '0));

    // R8: without a strobe every output holds.
    a_r8_hold_sign: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(dac_sign));
    a_r8_hold_therm: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(dac_therm));
    a_r8_hold_fine: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(dac_fine));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        logic [SEG_N-1:0]  t;
        logic [FINE_W-1:0] f;
        assign t = dac_therm[ch*SEG_N +: SEG_N];
        assign f = dac_fine[ch*FINE_W +: FINE_W];

        // R5: a negative sign always comes with a nonzero magnitude.
        a_r5_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
            dac_sign[ch] |-> (t != '0 || f != '0));

        // R6: a higher segment line is never on while a lower one is off.
        a_r6_therm_fill: assert property (@(posedge clk) disable iff (!rst_n)
            ((t >> 1) & ~t) == '0);
    end
endmodule

bind nssm_dac_encoder nssm_dac_encoder_chk #(
    .NUM_CH (NUM_CH),
    .IN_W   (IN_W),
    .FINE_W (FINE_W),
    .SEG_N  (SEG_N)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .dac_sign  (dac_sign),
    .dac_therm (dac_therm),
    .dac_fine  (dac_fine)
);

// File: tb/nssm_dac_encoder_bench.sv
// Bench: behavioural reference model compared against the outputs every clock.
module nssm_dac_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int INW  = 22;
    localparam int SEGS = 31;
    localparam int FW   = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [NCH*INW-1:0] smp_data = '0;
    logic [NCH-1:0]     dac_sign;
    logic [NCH*SEGS-1:0] dac_therm;
    logic [NCH*FW-1:0]  dac_fine;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    int in_val [NCH];
    int err_m  [NCH];
    int sgn_m  [NCH];
    int mag_m  [NCH];

    nssm_dac_encoder u_nssm_dac_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .dac_sign  (dac_sign),
        .dac_therm (dac_therm),
        .dac_fine  (dac_fine)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance the model by one edge using the values that were driven.
    task automatic model_edge(input bit rst_lvl, input bit vld);
        for (int ch = 0; ch < NCH; ch++) begin
            if (!rst_lvl) begin
                err_m[ch] = 0; sgn_m[ch] = 0; mag_m[ch] = 0;
            end else if (vld) begin
                int s, q;
                s = in_val[ch] + err_m[ch];
                q = s >>> 7;
                err_m[ch] = s & 127;
                if (q > 16383) q = 16383;
                if (q < -16384) q = -16384;
                sgn_m[ch] = (q < 0) ? 1 : 0;
                mag_m[ch] = (q == -16384) ? 16383 : ((q < 0) ? -q : q);
            end
        end
    endtask

    // Compare all fields of all channels with the model.
    task automatic compare();
        for (int ch = 0; ch < NCH; ch++) begin
            logic [SEGS-1:0] exp_t;
            int coarse;
            coarse = mag_m[ch] >> 9;
            for (int k = 0; k < SEGS; k++) exp_t[k] = (coarse > k);
            checks++;
            if (dac_sign[ch] !== sgn_m[ch][0]) begin
                fails++;
                $display("FAIL %s/R4 ch%0d sign act %0b exp %0d", tag, ch, dac_sign[ch], sgn_m[ch]);
            end else if (dac_therm[ch*SEGS +: SEGS] !== exp_t) begin
                fails++;
                $display("FAIL %s/R6 ch%0d therm act %h exp %h", tag, ch,
                         dac_therm[ch*SEGS +: SEGS], exp_t);
            end else if (dac_fine[ch*FW +: FW] !== mag_m[ch][8:0]) begin
                fails++;
                $display("FAIL %s/R7 ch%0d fine act %0d exp %0d", tag, ch,
                         dac_fine[ch*FW +: FW], mag_m[ch] & 511);
            end
        end
    endtask

    // One clock: drive at falling edge, update model at rising edge, sample after.
    task automatic step(input bit rst_lvl, input bit vld);
        @(negedge clk);
        rst_n = rst_lvl;
        smp_valid = vld;
        for (int ch = 0; ch < NCH; ch++) smp_data[ch*INW +: INW] = in_val[ch][INW-1:0];
        @(posedge clk);
        model_edge(rst_lvl, vld);
        #1;
        compare();
    endtask

    function automatic int rnd_sample();
        return int'($urandom % 4194304) - 2097152;
    endfunction

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            in_val[ch] = 0; err_m[ch] = 0; sgn_m[ch] = 0; mag_m[ch] = 0;
        end
        // R1: reset with strobes present and nonzero data.
        tag = "R1";
        for (int ch = 0; ch < NCH; ch++) in_val[ch] = 100000 * (ch + 1);
        repeat (3) step(1'b0, 1'b1);
        // R5: zero input right after reset gives an all-zero code.
        tag = "R5";
        for (int ch = 0; ch < NCH; ch++) in_val[ch] = 0;
        step(1'b1, 1'b1);
        // R2: small values that exercise the residue carry (e.g. 100 + 100 = 200 -> 1, err 72).
        tag = "R2";
        for (int i = 0; i < 40; i++) begin
            for (int ch = 0; ch < NCH; ch++) in_val[ch] = (ch * 37 + i * 53) % 300 - 150;
            step(1'b1, 1'b1);
        end
        // R5: zero input after residue builds up still yields zero code.
        tag = "R5";
        for (int ch = 0; ch < NCH; ch++) in_val[ch] = 0;
        repeat (4) step(1'b1, 1'b1);
        // R3: positive full scale clamps; R4: negative full scale saturates magnitude.
        tag = "R3";
        for (int ch = 0; ch < NCH; ch++) in_val[ch] = (ch % 2 == 0) ? 2097151 : -2097152;
        repeat (6) step(1'b1, 1'b1);
        tag = "R4";
        for (int ch = 0; ch < NCH; ch++) in_val[ch] = -128 * (ch * 4000 + 1);
        repeat (4) step(1'b1, 1'b1);
        // R6: sweep segment boundaries (magnitude 511/512, 1023/1024, ...).
        tag = "R6";
        for (int c = 0; c < 32; c++) begin
            for (int ch = 0; ch < NCH; ch++)
                in_val[ch] = ((ch < 2) ? 1 : -1) * ((c * 512 + ((ch % 2) ? 0 : 511)) * 128);
            step(1'b1, 1'b1);
        end
        // R8: strobe low while data changes; outputs and residue hold.
        tag = "R8";
        for (int i = 0; i < 20; i++) begin
            for (int ch = 0; ch < NCH; ch++) in_val[ch] = rnd_sample();
            step(1'b1, (i % 3 == 2));
        end
        // R9: one channel moves while the others stay at zero.
        tag = "R9";
        for (int i = 0; i < 16; i++) begin
            for (int ch = 0; ch < NCH; ch++) in_val[ch] = (ch == i % NCH) ? rnd_sample() : 0;
            step(1'b1, 1'b1);
        end
        // R2: long random run with a mixed strobe pattern.
        tag = "R2";
        for (int i = 0; i < 400; i++) begin
            for (int ch = 0; ch < NCH; ch++) in_val[ch] = rnd_sample();
            step(1'b1, ($urandom % 4) != 0);
        end
        // R1: reset in the middle of traffic clears outputs and residue.
        tag = "R1";
        step(1'b0, 1'b1);
        for (int ch = 0; ch < NCH; ch++) in_val[ch] = 64;
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8 act timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule